// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block is a small, fully associative address translation cache. Each slot holds one mapping from a virtual page to a physical base, together with that page's size and its access attributes. A page-table walker fills the buffer through an insert port. A memory pipeline queries it through a lookup port and gets back either a physical address with the attributes, or a miss carrying the virtual address that could not be translated.

Every slot keeps its own page size: 4 KB, 2 MB or 4 MB. The number of low address bits that take part in matching therefore differs from slot to slot, and so does the number of bits copied from the virtual address into the physical address. After reset, empty slots are handed out in index order. Once all slots are in use, a round-robin pointer picks the slot to overwrite.

Top module: `tlbvps_top`

## Requirements
- R1: During reset and after it, every slot is empty. A lookup made before any insert reports a miss.
- R2: A lookup presented with lookValid high returns its result with respValid high on the next clock cycle. In every other cycle respValid and respHit are low.
- R3: The page size code is 2'b00 for 4 KB, 2'b01 for 2 MB and 2'b10 for 4 MB. The code 2'b11 is stored and reported as 4 KB (2'b00). A hit never reports 2'b11.
- R4: A lookup hits a valid slot when every virtual address bit at or above that slot's page-size boundary (bit 12, 21 or 22) equals the stored page address. The stored page address is the inserted address with its offset bits cleared.
- R5: On a hit, respPaddr is the slot's physical base with its offset bits cleared, ORed with the lookup address's offset bits for that slot's page size. Offset bits of the inserted physical base are ignored.
- R6: On a miss, respHit is 0, respPaddr, respSize and respAttr are 0, and respFaultVaddr equals the looked-up address. On a hit, respFaultVaddr is 0.
- R7: A hit returns the stored attributes on respAttr: bit 0 writable, bit 1 user, bit 2 no-execute, bit 3 global, bit 4 uncacheable, bit 5 PAT select.
- R8: While empty slots remain, each insert takes the lowest-numbered slot not yet used, so the first ENTRIES inserts fill slots 0 to ENTRIES-1 in that order.
- R9: Once every slot is used, each further insert overwrites the slot named by a round-robin pointer. The pointer starts at slot 0 and advances by one, with wrap, after each such insert.
- R10: When an insert and a lookup arrive in the same cycle, the insert always takes effect and is never dropped. The lookup result reflects the contents before that insert, and the new mapping is visible from the next cycle on.
- R11: When several valid slots match one address, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request |
| insVaddr | input | VA_W | Virtual address of the mapping to insert |
| insPbase | input | PA_W | Physical base of the mapping to insert |
| insSize | input | 2 | Page size code of the insert |
| insAttr | input | 6 | Attributes of the insert |
| lookValid | input | 1 | Lookup request |
| lookVaddr | input | VA_W | Virtual address to translate |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Lookup hit |
| respPaddr | output | PA_W | Translated physical address |
| respSize | output | 2 | Page size code of the hitting slot |
| respAttr | output | 6 | Attributes of the hitting slot |
| respFaultVaddr | output | VA_W | Virtual address that missed |

## Verification
The checker watches, on every cycle, the properties that do not depend on which slot matched. These are the one-cycle response timing, the miss payload that echoes the address, the passthrough of offset bits into the physical address for the reported page size, and the absence of the reserved size code on a hit. Which slot answers, and therefore the allocation order, the round-robin overwrite, the lowest-index tie-break, boundary matching for each size and the same-cycle insert/lookup ordering, can only be shown by the bench's scenarios. The bench checks each lookup against a reference model of the slot array.

// File: rtl/tlbvps_pkg.sv
package tlbvps_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_2M  = 2'b01,
    PG_4M  = 2'b10,
    PG_RSV = 2'b11
  } pgSize_e;

  // writable is bit 0, pat is bit 5
  typedef struct packed {
    logic pat;
    logic uncacheable;
    logic isGlobal;
    logic noExec;
    logic user;
    logic writable;
  } pteAttr_t;

  typedef struct packed {
    logic wrEn;
    logic lookEn;
  } tlbStrobe_t;

  localparam int OFF_4K = 12;
  localparam int OFF_2M = 21;
  localparam int OFF_4M = 22;

  function automatic pgSize_e normSize(input logic [1:0] code);
    case (code)
      2'b01:   return PG_2M;
      2'b10:   return PG_4M;
      default: return PG_4K;
    endcase
  endfunction

  function automatic int offBits(input pgSize_e sz);
    case (sz)
      PG_2M:   return OFF_2M;
      PG_4M:   return OFF_4M;
      default: return OFF_4K;
    endcase
  endfunction

endpackage

// File: rtl/tlbvps_ctrl.sv
module tlbvps_ctrl
  import tlbvps_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             lookValid,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx
);

  logic [IDX_W-1:0] freeHead;
  logic [IDX_W-1:0] rrPtr;
  logic             allUsed;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign strobe.wrEn   = insValid;
  assign strobe.lookEn = lookValid;
  assign wrIdx         = allUsed ? rrPtr : freeHead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeHead <= '0;
      rrPtr    <= '0;
      allUsed  <= 1'b0;
    end else if (insValid) begin
      if (allUsed) begin
        rrPtr <= stepIdx(rrPtr);
      end else begin
        freeHead <= stepIdx(freeHead);
        if (freeHead == IDX_W'(ENTRIES - 1)) allUsed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlbvps_dpath.sv
module tlbvps_dpath
  import tlbvps_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VA_W-1:0]  insVaddr,
  input  logic [PA_W-1:0]  insPbase,
  input  logic [1:0]       insSize,
  input  pteAttr_t         insAttr,
  input  logic [VA_W-1:0]  lookVaddr,
  output logic             respValid,
  output logic             respHit,
  output logic [PA_W-1:0]  respPaddr,
  output logic [1:0]       respSize,
  output pteAttr_t         respAttr,
  output logic [VA_W-1:0]  respFaultVaddr
);

  logic [ENTRIES-1:0] slotValid;
  logic [VA_W-1:0]    slotTag   [ENTRIES];
  logic [PA_W-1:0]    slotBase  [ENTRIES];
  pgSize_e            slotSize  [ENTRIES];
  pteAttr_t           slotAttr  [ENTRIES];
  logic [VA_W-1:0]    slotMask  [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  function automatic logic [VA_W-1:0] vMask(input pgSize_e sz);
    return (VA_W'(1) << offBits(sz)) - VA_W'(1);
  endfunction

  pgSize_e         insSizeN;
  logic [VA_W-1:0] insMask;
  assign insSizeN = normSize(insSize);
  assign insMask  = vMask(insSizeN);

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    assign slotMask[g] = vMask(slotSize[g]);
    assign hitVec[g]   = slotValid[g] && ((lookVaddr & ~slotMask[g]) == slotTag[g]);
  end

  logic             anyHit;
  logic [IDX_W-1:0] hitIdx;
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        slotTag[i]  <= '0;
        slotBase[i] <= '0;
        slotSize[i] <= PG_4K;
        slotAttr[i] <= '0;
      end
    end else if (strobe.wrEn) begin
      slotValid[wrIdx] <= 1'b1;
      slotTag[wrIdx]   <= insVaddr & ~insMask;
      slotBase[wrIdx]  <= insPbase & ~PA_W'(insMask);
      slotSize[wrIdx]  <= insSizeN;
      slotAttr[wrIdx]  <= insAttr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.lookEn) begin
      respValid      <= 1'b0;
      respHit        <= 1'b0;
      respPaddr      <= '0;
      respSize       <= 2'b00;
      respAttr       <= '0;
      respFaultVaddr <= '0;
    end else begin
      respValid <= 1'b1;
      respHit   <= anyHit;
      if (anyHit) begin
        respPaddr      <= slotBase[hitIdx] | PA_W'(lookVaddr & slotMask[hitIdx]);
        respSize       <= slotSize[hitIdx];
        respAttr       <= slotAttr[hitIdx];
        respFaultVaddr <= '0;
      end else begin
        respPaddr      <= '0;
        respSize       <= 2'b00;
        respAttr       <= '0;
        respFaultVaddr <= lookVaddr;
      end
    end
  end

endmodule

// File: rtl/tlbvps_top.sv
module tlbvps_top
  import tlbvps_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            insValid,
  input  logic [VA_W-1:0] insVaddr,
  input  logic [PA_W-1:0] insPbase,
  input  logic [1:0]      insSize,
  input  logic [5:0]      insAttr,
  input  logic            lookValid,
  input  logic [VA_W-1:0] lookVaddr,
  output logic            respValid,
  output logic            respHit,
  output logic [PA_W-1:0] respPaddr,
  output logic [1:0]      respSize,
  output logic [5:0]      respAttr,
  output logic [VA_W-1:0] respFaultVaddr
);

  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  pteAttr_t         attrOut;

  tlbvps_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .insValid  (insValid),
    .lookValid (lookValid),
    .strobe    (strobe),
    .wrIdx     (wrIdx)
  );

  tlbvps_dpath #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .wrIdx          (wrIdx),
    .insVaddr       (insVaddr),
    .insPbase       (insPbase),
    .insSize        (insSize),
    .insAttr        (pteAttr_t'(insAttr)),
    .lookVaddr      (lookVaddr),
    .respValid      (respValid),
    .respHit        (respHit),
    .respPaddr      (respPaddr),
    .respSize       (respSize),
    .respAttr       (attrOut),
    .respFaultVaddr (respFaultVaddr)
  );

  assign respAttr = attrOut;

endmodule

// File: rtl/tlbvps_chk.sv
module tlbvps_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rstN,
  input logic            lookValid,
  input logic [VA_W-1:0] lookVaddr,
  input logic            respValid,
  input logic            respHit,
  input logic [PA_W-1:0] respPaddr,
  input logic [1:0]      respSize,
  input logic [VA_W-1:0] respFaultVaddr
);

  logic [VA_W-1:0] offMask;
  always_comb begin
    case (respSize)
      2'b01:   offMask = VA_W'(32'h001F_FFFF);
      2'b10:   offMask = VA_W'(32'h003F_FFFF);
      default: offMask = VA_W'(32'h0000_0FFF);
    endcase
  end

  assert_resp_follows_look_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookValid |=> respValid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookValid |=> !respValid);

  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !respHit);

  assert_miss_echoes_vaddr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respFaultVaddr == $past(lookVaddr) && respPaddr == '0));

  assert_offset_passthrough_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> ((respPaddr & PA_W'(offMask)) == PA_W'($past(lookVaddr) & offMask)));

  assert_size_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respSize != 2'b11);

endmodule

bind tlbvps_top tlbvps_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .lookValid      (lookValid),
  .lookVaddr      (lookVaddr),
  .respValid      (respValid),
  .respHit        (respHit),
  .respPaddr      (respPaddr),
  .respSize       (respSize),
  .respFaultVaddr (respFaultVaddr)
);

// File: tb/tb_tlbvps_top.sv
`timescale 1ns/1ps
module tb_tlbvps_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 1'b0;
  logic [31:0] insVaddr = '0;
  logic [35:0] insPbase = '0;
  logic [1:0]  insSize = '0;
  logic [5:0]  insAttr = '0;
  logic        lookValid = 1'b0;
  logic [31:0] lookVaddr = '0;
  logic        respValid, respHit;
  logic [35:0] respPaddr;
  logic [1:0]  respSize;
  logic [5:0]  respAttr;
  logic [31:0] respFaultVaddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlbvps_top dut (.*);

  // reference model
  bit          mV  [N];
  logic [31:0] mTag[N];
  logic [35:0] mPb [N];
  logic [1:0]  mSz [N];
  logic [5:0]  mAt [N];
  int          mHead = 0;
  int          mRr = 0;
  bit          mFull = 1'b0;

  function automatic logic [31:0] maskOf(input logic [1:0] s);
    case (s)
      2'b01:   return 32'h001F_FFFF;
      2'b10:   return 32'h003F_FFFF;
      default: return 32'h0000_0FFF;
    endcase
  endfunction

  function automatic logic [1:0] sizeNorm(input logic [1:0] s);
    return (s == 2'b11) ? 2'b00 : s;
  endfunction

  task automatic modelInsert(input logic [31:0] va, input logic [35:0] pb,
                             input logic [1:0] s, input logic [5:0] at);
    int k;
    logic [1:0] ns;
    ns = sizeNorm(s);
    if (mFull) begin k = mRr; mRr = (mRr + 1) % N; end
    else begin k = mHead; mHead++; if (mHead == N) mFull = 1'b1; end
    mV[k] = 1'b1;
    mTag[k] = va & ~maskOf(ns);
    mPb[k] = pb & ~{4'h0, maskOf(ns)};
    mSz[k] = ns;
    mAt[k] = at;
  endtask

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // called at a negedge; drives one cycle and checks the response
  task automatic doStep(input bit iv, input logic [31:0] ia, input logic [35:0] ip,
                        input logic [1:0] is, input logic [5:0] iat,
                        input bit lv, input logic [31:0] la, input string tag);
    bit eH = 1'b0;
    logic [35:0] eP = '0;
    logic [1:0] eS = '0;
    logic [5:0] eA = '0;
    logic [31:0] eF = la;
    insValid = iv; insVaddr = ia; insPbase = ip; insSize = is; insAttr = iat;
    lookValid = lv; lookVaddr = la;
    for (int k = N - 1; k >= 0; k--) begin
      if (mV[k] && ((la & ~maskOf(mSz[k])) == mTag[k])) begin
        eH = 1'b1;
        eP = mPb[k] | {4'h0, la & maskOf(mSz[k])};
        eS = mSz[k]; eA = mAt[k]; eF = '0;
      end
    end
    if (!eH) eF = la;
    if (iv) modelInsert(ia, ip, is, iat);
    @(posedge clk); #1;
    if (lv) begin
      check(respValid && respHit == eH && respPaddr == eP && respSize == eS &&
            respAttr == eA && respFaultVaddr == eF, tag,
            $sformatf("actual v=%0b h=%0b pa=%h sz=%0d at=%h fv=%h expected v=1 h=%0b pa=%h sz=%0d at=%h fv=%h",
                      respValid, respHit, respPaddr, respSize, respAttr, respFaultVaddr,
                      eH, eP, eS, eA, eF));
    end else begin
      check(!respValid && !respHit, tag,
            $sformatf("idle actual v=%0b h=%0b expected v=0 h=0", respValid, respHit));
    end
    @(negedge clk);
    insValid = 1'b0; lookValid = 1'b0;
  endtask

  task automatic ins(input logic [31:0] va, input logic [35:0] pb, input logic [1:0] s,
                     input logic [5:0] at, input string tag);
    doStep(1'b1, va, pb, s, at, 1'b0, '0, tag);
  endtask

  task automatic look(input logic [31:0] va, input string tag);
    doStep(1'b0, '0, '0, '0, '0, 1'b1, va, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) mV[k] = 1'b0;
    lookValid = 1'b1; lookVaddr = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset even with a lookup asserted
    check(!respValid && !respHit, "R1",
          $sformatf("reset actual v=%0b h=%0b expected v=0 h=0", respValid, respHit));
    lookValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    look(32'h1234_5678, "R1");                                   // empty -> miss
    doStep(1'b0, '0, '0, '0, '0, 1'b0, '0, "R2");                 // idle cycle

    // R4: 2 MB page boundary
    ins(32'h1060_1234, 36'h8_1234_5678, 2'b01, 6'b000011, "R4");
    look(32'h1060_0000, "R4");
    look(32'h107F_FFFF, "R4");
    look(32'h1080_0000, "R4");
    look(32'h105F_FFFF, "R4");

    // R5 / R7: 4 KB page, dirty low physical bits, attributes
    ins(32'h2345_6789, 36'hA_BCDE_FFFF, 2'b00, 6'b101010, "R5");
    look(32'h2345_6ABC, "R5");
    look(32'h2345_6000, "R7");
    look(32'h2345_7000, "R4");

    // R3: 4 MB page and the reserved code
    ins(32'h4080_0000, 36'h3_0000_0000, 2'b10, 6'b010101, "R3");
    look(32'h40BF_FFFF, "R3");
    ins(32'h4200_0000, 36'h4_0000_0000, 2'b11, 6'b111111, "R3");
    look(32'h4200_0FFF, "R3");
    look(32'h4200_1000, "R3");

    // R10: same-cycle insert and lookup
    doStep(1'b1, 32'h6000_0000, 36'h5_5550_0000, 2'b00, 6'b000001,
           1'b1, 32'h6000_0010, "R10");
    look(32'h6000_0010, "R10");

    // R8: fill remaining free slots in order, then all hit
    for (int k = 0; k < 3; k++)
      ins(32'h7000_0000 + k * 32'h1000, 36'h1_0000_0000 + k * 36'h1000, 2'b00, 6'(k), "R8");
    for (int k = 0; k < 3; k++) look(32'h7000_0004 + k * 32'h1000, "R8");
    look(32'h1060_0004, "R8");

    // R9: round-robin overwrite starting at slot 0
    ins(32'h7100_0000, 36'h2_0000_0000, 2'b00, 6'b000100, "R9");
    look(32'h1060_0004, "R9");       // slot 0 gone
    look(32'h2345_6004, "R9");       // slot 1 still there
    ins(32'h7200_0000, 36'h2_1000_0000, 2'b00, 6'b000100, "R9");
    look(32'h2345_6004, "R9");       // slot 1 gone
    look(32'h40BF_0000, "R9");       // slot 2 still there

    // R11: overlapping pages, lower slot answers
    ins(32'h3000_0000, 36'h9_0000_0000, 2'b10, 6'b000001, "R11");
    ins(32'h3000_5000, 36'h9_8000_0000, 2'b00, 6'b000010, "R11");
    look(32'h3000_5123, "R11");

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit iv, lv;
      logic [31:0] ia, la;
      logic [35:0] ip;
      iv = ($urandom % 10) < 3;
      lv = ($urandom % 10) < 7;
      ia = 32'h5000_0000 | (($urandom % 4) << 22) | ($urandom & 32'h003F_FFFF);
      la = 32'h5000_0000 | (($urandom % 4) << 22) | ($urandom & 32'h003F_FFFF);
      ip = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      doStep(iv, ia, ip, 2'($urandom % 4), 6'($urandom % 64), lv, la,
             iv && lv ? "R10" : (lv ? "R4" : "R2"));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule